// File: doc/BRIEF.md
# Transmit descriptor engine

This block drives frame transmission from a ring of buffer descriptors held in a shared descriptor RAM. Each descriptor takes two consecutive RAM words: a control/status word at an even index and the buffer's byte address at the index after it. While transmit is enabled, the engine polls the control word at its current ring index until software marks it ready. It then works out the frame's length policy and CRC option from the descriptor flags and the global mode bits. Next it fetches the payload from memory one 32-bit word at a time and streams the bytes out on a byte-wide valid/ready port.

Once the last byte has gone out, the engine waits for the downstream side to report the outcome on `tx_done`/`tx_fail`. It then writes the control word back with ready cleared and pulses an interrupt-source set strobe. It also pulses the interrupt line when either mask bit is set. Finally it moves the ring index, either to the next slot or back to zero.

The engine does not compute a CRC and does not handle collisions or retries. It only exports the per-frame CRC decision and the length limits on `frm_*` for the downstream framer.

Top module: `txd_engine`

## Requirements
- R1: After reset the engine is idle. All strobes are low, `tx_valid` and `mem_req` are low, and the ring index is 0. While `cfg_tx_en` is low, `bd_rd_en` stays low and no descriptor is read.
- R2: While `cfg_tx_en` is high and the control word at the ring index has ready (bit 15) clear, the engine keeps polling that word (`bd_rd_en` high, same address). If `cfg_tx_en` drops during polling, the engine returns to idle and `bd_rd_en` goes low.
- R3: A descriptor at index i has its control word at RAM word i and its buffer address at word i+1. In the control word, bits [31:16] give the frame length in bytes, bit 15 is ready, bit 14 last, bit 13 wrap, bit 12 pad and bit 11 CRC request.
- R4: On completion, the control word is written back to index i. In that write, ready (bit 15) and the status bits [8:0] are zero: underrun 8, retry count [7:4], retransmit 3, defer 2, collision 1, no-carrier 0. All other bits keep the values software wrote.
- R5: `frm_min_len` equals bits [31:16] of `cfg_frame_limits` when the descriptor pad flag or `cfg_pad_all` is set. Otherwise it equals the frame length.
- R6: `frm_max_len` equals the frame length when `cfg_huge_en` is set. Otherwise it equals bits [15:0] of `cfg_frame_limits`.
- R7: `frm_add_crc` is 1 when `cfg_crc_all` is set, or when the descriptor has both its CRC and last flags set. Otherwise it is 0.
- R8: The payload is fetched as 32-bit words from buffer address plus byte offset, with the offset stepping by 4 and at most one read outstanding. Each word's bytes go out most significant first. A byte is held stable while `tx_ready` is low.
- R9: Exactly frame-length bytes go out on the stream, including when the last word is only partly used. A zero-length frame issues no memory reads and sends no bytes.
- R10: `tx_done` is sampled only after all bytes have gone out. With `tx_fail` low it pulses `int_set_txb`; with `tx_fail` high it pulses `int_set_txe`. Never both at once.
- R11: After completion the index becomes 0 if the descriptor's wrap flag was set or the index was the last slot (BD_WORDS-2). Otherwise it advances by 2.
- R12: `irq_pulse` pulses at completion when `cfg_mask_txb` or `cfg_mask_txe` is set, and stays low when both are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_en | input | 1 | Global transmit enable |
| cfg_pad_all | input | 1 | Global pad mode: apply minimum length to every frame |
| cfg_huge_en | input | 1 | Huge-frame enable: no maximum beyond the frame length |
| cfg_crc_all | input | 1 | Global CRC append enable |
| cfg_frame_limits | input | 32 | [31:16] minimum frame length, [15:0] maximum frame length |
| cfg_mask_txb | input | 1 | Interrupt mask bit for good transmit |
| cfg_mask_txe | input | 1 | Interrupt mask bit for transmit error |
| bd_rd_en | output | 1 | Descriptor RAM read enable |
| bd_rd_addr | output | $clog2(BD_WORDS) | Descriptor RAM read word index |
| bd_rd_data | input | 32 | Descriptor RAM read data (same-cycle) |
| bd_wr_en | output | 1 | Descriptor RAM write strobe |
| bd_wr_addr | output | $clog2(BD_WORDS) | Descriptor RAM write word index |
| bd_wr_data | output | 32 | Descriptor RAM write data |
| mem_req | output | 1 | Memory word read request (one-cycle pulse) |
| mem_addr | output | 32 | Memory byte address of the requested word |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | 32 | Memory read response word |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_done | input | 1 | Downstream reports the frame finished |
| tx_fail | input | 1 | Qualifies `tx_done`: frame failed |
| frm_len | output | 16 | Length of the current frame |
| frm_min_len | output | 16 | Minimum length policy of the current frame |
| frm_max_len | output | 16 | Maximum length policy of the current frame |
| frm_add_crc | output | 1 | CRC append decision of the current frame |
| int_set_txb | output | 1 | Set strobe for the good-transmit interrupt source |
| int_set_txe | output | 1 | Set strobe for the transmit-error interrupt source |
| irq_pulse | output | 1 | Interrupt pulse |

## Verification
The bench walks the ring through every exit from a slot:
- a plain step of 2;
- a wrap on the descriptor flag;
- a wrap forced by the last slot of a small ring.

A design that misjudged the last-slot boundary would read past the ring, and one that ignored the wrap flag would poll the wrong slot.

The frames use lengths that are not multiples of four, a zero length and stream backpressure. These catch extra padding bytes from a partly used last word, memory reads issued for an empty frame, and bytes dropped or repeated while `tx_ready` is low.

The length and CRC policy is driven from each source in turn: the descriptor flags alone, the global bits alone, and CRC requested without last. An inverted OR or a missing AND in that decision shows up as a wrong `frm_*` value.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int DW = 32;
  localparam int LW = 16;

  // control word bit positions (decoded by software and by this engine)
  localparam int B_RDY  = 15;
  localparam int B_LAST = 14;
  localparam int B_WRAP = 13;
  localparam int B_PAD  = 12;
  localparam int B_CRC  = 11;

  // status bits [8:0] cleared on accept: underrun, retry[7:4], retransmit, defer, collision, no-carrier
  localparam logic [DW-1:0] STAT_MASK = 32'h0000_01FF;
  localparam logic [DW-1:0] COLL_MASK = 32'h0000_0002;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_BD,
    ST_GET_PTR,
    ST_READ_DATA,
    ST_TRANSMIT
  } txd_state_e;

  typedef enum logic [1:0] {
    RD_REQ,
    RD_WAIT,
    RD_SEND
  } txd_rd_e;

  typedef struct packed {
    logic [LW-1:0] len;
    logic [LW-1:0] min_len;
    logic [LW-1:0] max_len;
    logic          add_crc;
  } txd_frame_t;
endpackage

// File: rtl/txd_policy.sv
module txd_policy
  import txd_pkg::*;
(
  input  logic [DW-1:0] ctrl_word,
  input  logic          pad_all,
  input  logic          huge_en,
  input  logic          crc_all,
  input  logic [DW-1:0] limits,
  output txd_frame_t    frame,
  output logic [DW-1:0] ctrl_clean
);
  logic [LW-1:0] len_w;

  always_comb begin
    len_w         = ctrl_word[DW-1:LW];
    frame.len     = len_w;
    frame.min_len = (ctrl_word[B_PAD] || pad_all) ? limits[DW-1:LW] : len_w;
    frame.max_len = huge_en ? len_w : limits[LW-1:0];
    frame.add_crc = crc_all || (ctrl_word[B_CRC] && ctrl_word[B_LAST]);
    ctrl_clean    = ctrl_word & ~STAT_MASK;
  end
endmodule

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
  parameter int BD_WORDS = 128
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        advance,
  input  logic                        wrap_flag,
  output logic [$clog2(BD_WORDS)-1:0] idx
);
  localparam int IW = $clog2(BD_WORDS);
  localparam logic [IW-1:0] LAST_SLOT = IW'(BD_WORDS - 2);

  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (advance) begin
      if (wrap_flag || (idx_q >= LAST_SLOT)) idx_d = '0;
      else                                   idx_d = idx_q + IW'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= idx_d;
  end

  assign idx = idx_q;

  p_idx_even_r11: assert property (@(posedge clk) disable iff (!rst_n) idx_q[0] == 1'b0);
  p_idx_in_ring_r11: assert property (@(posedge clk) disable iff (!rst_n) idx_q <= LAST_SLOT);
  p_idx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n) !advance |=> $stable(idx_q));
endmodule

// File: rtl/txd_byte_stream.sv
module txd_byte_stream
  import txd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] word,
  input  logic [2:0]    nbytes,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          busy
);
  logic [DW-1:0] sh_q, sh_d;
  logic [2:0]    cnt_q, cnt_d;
  logic          en;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    en    = 1'b0;
    if (load && (cnt_q == 3'd0)) begin
      sh_d  = word;
      cnt_d = nbytes;
      en    = 1'b1;
    end else if ((cnt_q != 3'd0) && tx_ready) begin
      sh_d  = {sh_q[DW-9:0], 8'h00};
      cnt_d = cnt_q - 3'd1;
      en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign tx_valid = (cnt_q != 3'd0);
  assign busy     = tx_valid;
  assign tx_data  = sh_q[DW-1:DW-8];

  p_hold_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_cnt_max_r9: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= 3'd4);
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int BD_WORDS = 128
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_tx_en,
  input  logic                        cfg_pad_all,
  input  logic                        cfg_huge_en,
  input  logic                        cfg_crc_all,
  input  logic [31:0]                 cfg_frame_limits,
  input  logic                        cfg_mask_txb,
  input  logic                        cfg_mask_txe,
  output logic                        bd_rd_en,
  output logic [$clog2(BD_WORDS)-1:0] bd_rd_addr,
  input  logic [31:0]                 bd_rd_data,
  output logic                        bd_wr_en,
  output logic [$clog2(BD_WORDS)-1:0] bd_wr_addr,
  output logic [31:0]                 bd_wr_data,
  output logic                        mem_req,
  output logic [31:0]                 mem_addr,
  input  logic                        mem_rvalid,
  input  logic [31:0]                 mem_rdata,
  output logic                        tx_valid,
  output logic [7:0]                  tx_data,
  input  logic                        tx_ready,
  input  logic                        tx_done,
  input  logic                        tx_fail,
  output logic [15:0]                 frm_len,
  output logic [15:0]                 frm_min_len,
  output logic [15:0]                 frm_max_len,
  output logic                        frm_add_crc,
  output logic                        int_set_txb,
  output logic                        int_set_txe,
  output logic                        irq_pulse
);
  localparam int IW = $clog2(BD_WORDS);
  localparam int OW = LW + 1;

  txd_state_e    st_q, st_d;
  txd_rd_e       rp_q, rp_d;
  logic [OW-1:0] off_q, off_d;
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0] buf_q, buf_d;
  txd_frame_t    frm_q, frm_d;
  logic          acc_en, ptr_en;

  logic [IW-1:0] idx;
  logic          advance;
  txd_frame_t    pol_frame;
  logic [DW-1:0] pol_clean;
  logic          sb_busy, sb_load;
  logic [OW-1:0] rem;
  logic [2:0]    nbytes;

  logic          wb_en_d, txb_d, txe_d, irq_d;
  logic [DW-1:0] wb_data_d;
  logic          wb_en_q, txb_q, txe_q, irq_q;
  logic [DW-1:0] wb_data_q;
  logic [IW-1:0] wb_addr_q;

  txd_policy u_policy (
    .ctrl_word  (bd_rd_data),
    .pad_all    (cfg_pad_all),
    .huge_en    (cfg_huge_en),
    .crc_all    (cfg_crc_all),
    .limits     (cfg_frame_limits),
    .frame      (pol_frame),
    .ctrl_clean (pol_clean)
  );

  txd_ring_ptr #(.BD_WORDS(BD_WORDS)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .wrap_flag (ctrl_q[B_WRAP]),
    .idx       (idx)
  );

  txd_byte_stream u_stream (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sb_load),
    .word     (mem_rdata),
    .nbytes   (nbytes),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .busy     (sb_busy)
  );

  assign rem    = {1'b0, frm_q.len} - off_q;
  assign nbytes = (rem >= OW'(4)) ? 3'd4 : rem[2:0];

  // next-state logic
  always_comb begin
    st_d      = st_q;
    rp_d      = rp_q;
    off_d     = off_q;
    ctrl_d    = ctrl_q;
    buf_d     = buf_q;
    frm_d     = frm_q;
    acc_en    = 1'b0;
    ptr_en    = 1'b0;
    bd_rd_en  = 1'b0;
    bd_rd_addr = idx;
    mem_req   = 1'b0;
    sb_load   = 1'b0;
    advance   = 1'b0;
    wb_en_d   = 1'b0;
    wb_data_d = ctrl_q & ~(32'h1 << B_RDY);
    txb_d     = 1'b0;
    txe_d     = 1'b0;
    irq_d     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cfg_tx_en) st_d = ST_WAIT_BD;
      end
      ST_WAIT_BD: begin
        bd_rd_en = 1'b1;
        if (bd_rd_data[B_RDY]) begin
          ctrl_d = pol_clean;
          frm_d  = pol_frame;
          acc_en = 1'b1;
          st_d   = ST_GET_PTR;
        end else if (!cfg_tx_en) begin
          st_d = ST_IDLE;
        end
      end
      ST_GET_PTR: begin
        bd_rd_en   = 1'b1;
        bd_rd_addr = idx + IW'(1);
        buf_d      = bd_rd_data;
        off_d      = '0;
        rp_d       = RD_REQ;
        ptr_en     = 1'b1;
        st_d       = ST_READ_DATA;
      end
      ST_READ_DATA: begin
        unique case (rp_q)
          RD_REQ: begin
            if (off_q >= {1'b0, frm_q.len}) begin
              st_d = ST_TRANSMIT;
            end else begin
              mem_req = 1'b1;
              rp_d    = RD_WAIT;
            end
          end
          RD_WAIT: begin
            if (mem_rvalid) begin
              sb_load = 1'b1;
              off_d   = off_q + OW'(4);
              rp_d    = RD_SEND;
            end
          end
          default: begin
            if (!sb_busy) rp_d = RD_REQ;
          end
        endcase
      end
      default: begin
        if (tx_done) begin
          if (tx_fail) wb_data_d = ctrl_q & ~(32'h1 << B_RDY) & ~COLL_MASK;
          wb_en_d = 1'b1;
          txb_d   = !tx_fail;
          txe_d   = tx_fail;
          irq_d   = cfg_mask_txb || cfg_mask_txe;
          advance = 1'b1;
          st_d    = ST_IDLE;
        end
      end
    endcase
  end

  assign mem_addr = buf_q + {{(DW-OW){1'b0}}, off_q};

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rp_q  <= RD_REQ;
      off_q <= '0;
    end else begin
      st_q  <= st_d;
      rp_q  <= rp_d;
      off_q <= off_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      frm_q  <= '0;
    end else if (acc_en) begin
      ctrl_q <= ctrl_d;
      frm_q  <= frm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (ptr_en) buf_q <= buf_d;
  end

  // completion strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en_q <= 1'b0;
      txb_q   <= 1'b0;
      txe_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      wb_en_q <= wb_en_d;
      txb_q   <= txb_d;
      txe_q   <= txe_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_data_q <= '0;
      wb_addr_q <= '0;
    end else if (wb_en_d) begin
      wb_data_q <= wb_data_d;
      wb_addr_q <= idx;
    end
  end

  assign bd_wr_en    = wb_en_q;
  assign bd_wr_addr  = wb_addr_q;
  assign bd_wr_data  = wb_data_q;
  assign int_set_txb = txb_q;
  assign int_set_txe = txe_q;
  assign irq_pulse   = irq_q;
  assign frm_len     = frm_q.len;
  assign frm_min_len = frm_q.min_len;
  assign frm_max_len = frm_q.max_len;
  assign frm_add_crc = frm_q.add_crc;

  p_one_source_r10: assert property (@(posedge clk) disable iff (!rst_n) !(int_set_txb && int_set_txe));
  p_wb_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bd_wr_en |-> (bd_wr_data[B_RDY] == 1'b0 && (bd_wr_data & STAT_MASK) == '0));
  p_wb_with_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bd_wr_en |-> (int_set_txb || int_set_txe));
  p_irq_with_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (int_set_txb || int_set_txe));
  p_single_req_r8: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req);
  p_no_read_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !bd_rd_en);
  p_req_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (off_q < {1'b0, frm_q.len}));
endmodule

// File: tb/txd_engine_bench.sv
module txd_engine_bench;
  localparam int BDW = 8;
  localparam int IW  = $clog2(BDW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_tx_en = 1'b0, cfg_pad_all = 1'b0, cfg_huge_en = 1'b0, cfg_crc_all = 1'b0;
  logic [31:0] cfg_frame_limits = 32'h003C_0600;
  logic        cfg_mask_txb = 1'b0, cfg_mask_txe = 1'b0;
  logic        bd_rd_en, bd_wr_en, mem_req, tx_valid;
  logic [IW-1:0] bd_rd_addr, bd_wr_addr;
  logic [31:0] bd_rd_data, bd_wr_data, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1, tx_done = 1'b0, tx_fail = 1'b0;
  logic [15:0] frm_len, frm_min_len, frm_max_len;
  logic        frm_add_crc, int_set_txb, int_set_txe, irq_pulse;

  txd_engine #(.BD_WORDS(BDW)) u_txd_engine (.*);

  logic [31:0] bdram [0:BDW-1];
  assign bd_rd_data = bdram[bd_rd_addr];

  function automatic logic [31:0] mword(input logic [31:0] a);
    return {(a[7:0]) ^ 8'h5A, (a[7:0] + 8'd1) ^ 8'h5A, (a[7:0] + 8'd2) ^ 8'h5A, (a[7:0] + 8'd3) ^ 8'h5A};
  endfunction

  // memory model: response two cycles after request
  logic        pend = 1'b0;
  logic [31:0] paddr = '0;
  always @(posedge clk) begin
    pend       <= mem_req;
    paddr      <= mem_addr;
    mem_rvalid <= pend;
    mem_rdata  <= mword(paddr);
  end

  // monitors
  int unsigned cap_cnt = 0, req_cnt = 0, wr_cnt = 0, txb_cnt = 0, txe_cnt = 0, irq_cnt = 0;
  logic [7:0]  cap [0:255];
  logic [31:0] req_log [0:63];
  logic [31:0] last_wr_data = '0;
  logic [IW-1:0] last_wr_addr = '0;
  logic        bp_mode = 1'b0;

  always @(posedge clk) begin
    if (tx_valid && tx_ready) begin cap[cap_cnt[7:0]] <= tx_data; cap_cnt <= cap_cnt + 1; end
    if (mem_req) begin req_log[req_cnt[5:0]] <= mem_addr; req_cnt <= req_cnt + 1; end
    if (bd_wr_en) begin
      bdram[bd_wr_addr] <= bd_wr_data;
      last_wr_data <= bd_wr_data; last_wr_addr <= bd_wr_addr; wr_cnt <= wr_cnt + 1;
    end
    if (int_set_txb) txb_cnt <= txb_cnt + 1;
    if (int_set_txe) txe_cnt <= txe_cnt + 1;
    if (irq_pulse)   irq_cnt <= irq_cnt + 1;
  end

  always @(negedge clk) tx_ready <= bp_mode ? ~tx_ready : 1'b1;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // put a descriptor in place and run it to completion
  task automatic run_frame(input int idx, input logic [31:0] ctrl, input logic [31:0] bufa,
                           input logic fail, input int next_idx, input string tag);
    int c0 = cap_cnt, r0 = req_cnt, w0 = wr_cnt, b0 = txb_cnt, e0 = txe_cnt, i0 = irq_cnt;
    int len = int'(ctrl[31:16]);
    int guard = 0;
    @(negedge clk);
    bdram[idx + 1] = bufa;
    bdram[idx]     = ctrl;
    while ((cap_cnt - c0) < len && guard < 2000) begin @(negedge clk); guard++; end
    cyc(10);
    tx_fail = fail; tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0; tx_fail = 1'b0;
    cyc(4);
    // R9: exact byte count; R8: values MSB first
    chk({tag, " R9 byte count"}, cap_cnt - c0, len);
    for (int k = 0; k < len; k++)
      chk({tag, " R8 byte value"}, {24'h0, cap[(c0 + k) % 256]}, {24'h0, (bufa[7:0] + 8'(k)) ^ 8'h5A});
    chk({tag, " R8 word reads"}, req_cnt - r0, (len + 3) / 4);
    for (int k = 0; k < (len + 3) / 4; k++)
      chk({tag, " R8 read address"}, req_log[(r0 + k) % 64], bufa + 32'(4 * k));
    chk({tag, " R4 one write-back"}, wr_cnt - w0, 1);
    chk({tag, " R4 write-back index"}, {29'h0, last_wr_addr}, idx);
    chk({tag, " R4 write-back word"}, last_wr_data, ctrl & ~32'h0000_81FF);
    chk({tag, " R10 txb"}, txb_cnt - b0, fail ? 0 : 1);
    chk({tag, " R10 txe"}, txe_cnt - e0, fail ? 1 : 0);
    chk({tag, " R12 irq"}, irq_cnt - i0, (cfg_mask_txb || cfg_mask_txe) ? 1 : 0);
    chk({tag, " R11 next poll index"}, {29'h0, bd_rd_addr}, next_idx);
    chk({tag, " R11 polling"}, {31'h0, bd_rd_en}, 1);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1 bd_rd_en low", {31'h0, bd_rd_en}, 0);
    chk("R1 tx_valid low", {31'h0, tx_valid}, 0);
    chk("R1 mem_req low", {31'h0, mem_req}, 0);
    chk("R1 strobes low", {29'h0, bd_wr_en, int_set_txb, int_set_txe}, 0);
    chk("R1 irq low", {31'h0, irq_pulse}, 0);
  endtask

  task automatic t_poll();
    cfg_tx_en = 1'b1;
    cyc(4);
    chk("R2 polling while not ready", {31'h0, bd_rd_en}, 1);
    chk("R3 control word at index 0", {29'h0, bd_rd_addr}, 0);
    cfg_tx_en = 1'b0;
    cyc(3);
    chk("R2 idle after disable", {31'h0, bd_rd_en}, 0);
    chk("R1 no read while disabled", {31'h0, mem_req | tx_valid}, 0);
    cfg_tx_en = 1'b1;
  endtask

  task automatic t_plain();
    // len 10, CRC flag without last, status junk in [9:0]
    cfg_mask_txb = 1'b1;
    run_frame(0, {16'd10, 16'h8BFF}, 32'h0000_0100, 1'b0, 2, "plain");
    chk("R5 min equals length", {16'h0, frm_min_len}, 10);
    chk("R6 max from limits", {16'h0, frm_max_len}, 32'h0600);
    chk("R7 no crc without last", {31'h0, frm_add_crc}, 0);
    chk("R3 length field", {16'h0, frm_len}, 10);
  endtask

  task automatic t_fail_wrap();
    // pad+wrap+crc+last, len 5, failure, masks clear
    cfg_mask_txb = 1'b0; cfg_mask_txe = 1'b0;
    run_frame(2, {16'd5, 16'hF802}, 32'h0000_0240, 1'b1, 0, "failwrap");
    chk("R5 min from pad flag", {16'h0, frm_min_len}, 32'h003C);
    chk("R7 crc from flags", {31'h0, frm_add_crc}, 1);
  endtask

  task automatic t_global_bp();
    cfg_pad_all = 1'b1; cfg_huge_en = 1'b1; cfg_crc_all = 1'b1; bp_mode = 1'b1;
    run_frame(0, {16'd8, 16'h8000}, 32'h0000_0380, 1'b0, 2, "global");
    chk("R6 max equals length", {16'h0, frm_max_len}, 8);
    chk("R5 min from pad mode", {16'h0, frm_min_len}, 32'h003C);
    chk("R7 crc from global", {31'h0, frm_add_crc}, 1);
    cfg_pad_all = 1'b0; cfg_huge_en = 1'b0; cfg_crc_all = 1'b0; bp_mode = 1'b0;
  endtask

  task automatic t_zero_and_last();
    run_frame(2, {16'd0, 16'h8000}, 32'h0000_0400, 1'b0, 4, "zero");
    cfg_mask_txe = 1'b1;
    run_frame(4, {16'd3, 16'h8000}, 32'h0000_0480, 1'b0, 6, "odd");
    cfg_mask_txe = 1'b0;
    run_frame(6, {16'd4, 16'h8000}, 32'h0000_04C0, 1'b0, 0, "lastslot");
  endtask

  int wd = 0;
  logic done_flag = 1'b0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000 && !done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", wd);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < BDW; i++) bdram[i] = 32'h0;
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_poll();
    t_plain();
    t_fail_wrap();
    t_global_bp();
    t_zero_and_last();
    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule